// File: doc/BRIEF.md
# Reloadable down-counting interval timer

This block is a down-counter with a small word-wide register window. Software stores a start value, picks one of two tick sources and a counting mode, then sets the enable bit. Each tick from the chosen source lowers the count by one. When the count is at zero and another tick arrives, the counter underflows. It then either reloads from the stored start value (periodic mode) or wraps to all ones (free-running mode). It also raises a level interrupt.

Ticks arrive from outside the block as one-cycle clock-enable strobes, so everything runs on one system clock. The interrupt stays high until software writes any value to the clear register. The counter width is a parameter, 16 or 32 bits, and both widths behave the same way. Register offsets are byte addresses: 0x0 holds the start value, 0x4 is the current count (read-only), 0x8 is control and 0xC is the interrupt clear.

Top module: `interval_timer`

## Requirements
- R1: After reset the count, the start value and control all read 0, and irq_o is low.
- R2: A write to offset 0x0 stores the start value (read back at 0x0) and copies it into the count, which can be read at 0x4 in the next cycle. A read of offset 0x8 returns only bits 7, 6 and 3 of control, and every other bit reads 0.
- R3: While control bit 7 (enable) is 0, ticks leave the count unchanged.
- R4: Control bit 3 = 1 selects tick_fast_i and bit 3 = 0 selects tick_slow_i. Strobes on the source that is not selected have no effect.
- R5: Each selected tick, with enable set and the count nonzero, lowers the count by exactly one.
- R6: In periodic mode (control bit 6 = 1), a tick at count 0 reloads the start value, so a start value N gives one interrupt every N+1 ticks.
- R7: In free-running mode (control bit 6 = 0), a tick at count 0 wraps the count to all ones and raises the interrupt.
- R8: irq_o goes high in the cycle after an underflow. It stays high until a write of any data to offset 0xC, and it is low from the next cycle on.
- R9: If an underflow and a clear write fall in the same cycle, irq_o stays high.
- R10: Writing 0 to control stops counting and leaves irq_o unchanged.
- R11: Writes to offset 0x4 have no effect on the count.
- R12: If a start-value write and a selected tick fall in the same cycle, the count takes the written value and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational from addr_i) |
| tick_fast_i | input | 1 | Fast tick strobe, one cycle wide |
| tick_slow_i | input | 1 | Slow tick strobe, one cycle wide |
| irq_o | output | 1 | Level interrupt, held until cleared |

## Verification
A wrong count shows on the value read-back in the cycle after the tick that caused it. An error at underflow shows up within N+1 ticks in one of two ways: the interrupt period drifts away from N+1, or the value after reload is wrong. The bench sweeps start values 0 to 6 across both modes and both tick sources, counting ticks between interrupts. An interrupt flag that is stuck or lost is seen on irq_o one cycle after the underflow, the clear write or the control write that should have touched it.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_LOAD  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_VALUE = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 4'hC;

  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_MODE = 6;
  localparam int unsigned BIT_SRC  = 3;

  typedef struct packed {
    logic en;
    logic periodic;
    logic src_fast;
  } ctrl_t;
endpackage

// File: rtl/timer_regfile.sv
module timer_regfile
  import timer_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  cnt_i,
  output logic [WIDTH-1:0]  load_o,
  output ctrl_t             ctrl_o,
  output logic              load_we_o,
  output logic              clr_we_o
);
  logic wr;
  logic ctrl_we;
  logic unused_wdata;

  assign wr        = req_i & we_i;
  assign load_we_o = wr & (addr_i == OFS_LOAD);
  assign ctrl_we   = wr & (addr_i == OFS_CTRL);
  assign clr_we_o  = wr & (addr_i == OFS_CLEAR);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o <= '0;
      ctrl_o <= '0;
    end else begin
      if (load_we_o) load_o <= wdata_i[WIDTH-1:0];
      if (ctrl_we) begin
        ctrl_o.en       <= wdata_i[BIT_EN];
        ctrl_o.periodic <= wdata_i[BIT_MODE];
        ctrl_o.src_fast <= wdata_i[BIT_SRC];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_LOAD:  rdata_o = BUS_W'(load_o);
      OFS_VALUE: rdata_o = BUS_W'(cnt_i);
      OFS_CTRL: begin
        rdata_o[BIT_EN]   = ctrl_o.en;
        rdata_o[BIT_MODE] = ctrl_o.periodic;
        rdata_o[BIT_SRC]  = ctrl_o.src_fast;
      end
      default: rdata_o = '0;
    endcase
  end

  // R2
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> (ctrl_o.en == $past(wdata_i[BIT_EN])));
endmodule

// File: rtl/timer_counter.sv
module timer_counter
  import timer_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic             tick_fast_i,
  input  logic             tick_slow_i,
  input  logic             load_we_i,
  input  logic [WIDTH-1:0] load_wdata_i,
  input  logic [WIDTH-1:0] load_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             uf_o
);
  logic tick;
  logic at_zero;

  assign tick    = ctrl_i.en & (ctrl_i.src_fast ? tick_fast_i : tick_slow_i);
  assign at_zero = (cnt_o == '0);
  assign uf_o    = tick & at_zero & ~load_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (load_we_i) begin
      cnt_o <= load_wdata_i;
    end else if (tick) begin
      if (at_zero) cnt_o <= ctrl_i.periodic ? load_i : '1;
      else         cnt_o <= cnt_o - 1'b1;
    end
  end

  // R3
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.en && !load_we_i) |=> $stable(cnt_o));
  // R5
  dec_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !at_zero && !load_we_i) |=> (cnt_o == $past(cnt_o) - 1'b1));
  // R6
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_o && ctrl_i.periodic) |=> (cnt_o == $past(load_i)));
  // R7
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_o && !ctrl_i.periodic) |=> (&cnt_o));
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uf_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (uf_i)  irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

  // R8
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |=> irq_o);
  // R8
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !uf_i) |=> !irq_o);
  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !uf_i) |=> $stable(irq_o));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              tick_fast_i,
  input  logic              tick_slow_i,
  output logic              irq_o
);
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] load_q;
  ctrl_t            ctrl;
  logic             load_we;
  logic             clr_we;
  logic             uf;

  initial begin
    width_ok_chk: assert (WIDTH == 16 || WIDTH == 32);
  end

  timer_regfile #(.WIDTH(WIDTH)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .load_o(load_q), .ctrl_o(ctrl),
    .load_we_o(load_we), .clr_we_o(clr_we)
  );

  timer_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .tick_fast_i, .tick_slow_i,
    .load_we_i(load_we), .load_wdata_i(wdata_i[WIDTH-1:0]),
    .load_i(load_q), .cnt_o(cnt), .uf_o(uf)
  );

  timer_irq u_irq (
    .clk_i, .rst_ni, .uf_i(uf), .clr_i(clr_we), .irq_o
  );

  // R12
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we |=> (cnt == $past(wdata_i[WIDTH-1:0])));
endmodule

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;
  localparam int W = 16;
  localparam logic [3:0] A_LOAD = 4'h0, A_VAL = 4'h4, A_CTRL = 4'h8, A_CLR = 4'hC;
  localparam logic [31:0] C_EN = 32'h80, C_PER = 32'h40, C_FAST = 32'h08;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, tf = 0, ts = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  interval_timer #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_fast_i(tf), .tick_slow_i(ts),
    .irq_o(irq)
  );

  task automatic chk(string req_s, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req_s, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic tick(bit fast);
    @(negedge clk); if (fast) tf = 1; else ts = 1;
    @(negedge clk); tf = 0; ts = 0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=1 exp=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(A_VAL, v);  chk("R1 count", v, 0);
    rd(A_LOAD, v); chk("R1 load", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", irq, 0);
    // R2
    wr(A_LOAD, 32'hABCD_1234);
    rd(A_LOAD, v); chk("R2 load readback", v, 32'h1234);
    rd(A_VAL, v);  chk("R2 count copy", v, 32'h1234);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R2 ctrl bits", v, 32'hC8);
    wr(A_CTRL, 0);
    // R3
    tick(1); tick(0);
    rd(A_VAL, v); chk("R3 hold disabled", v, 32'h1234);
    // R11
    wr(A_VAL, 32'h5);
    rd(A_VAL, v); chk("R11 value read-only", v, 32'h1234);
    // R4 / R5: both sources
    for (int s = 0; s < 2; s++) begin
      wr(A_LOAD, 20);
      wr(A_CTRL, C_EN | C_PER | (s ? C_FAST : 0));
      tick(s == 0);
      rd(A_VAL, v); chk("R4 other source ignored", v, 20);
      for (int k = 1; k <= 5; k++) begin
        tick(s == 1);
        rd(A_VAL, v); chk("R5 dec by one", v, 20 - k);
      end
    end
    // R6 / R8: periodic sweep
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n <= 6; n++) begin
        wr(A_CTRL, 0);
        wr(A_CLR, 0);
        wr(A_LOAD, n);
        wr(A_CTRL, C_EN | C_PER | (s ? C_FAST : 0));
        for (int p = 0; p < 2; p++) begin
          for (int k = 0; k < n; k++) begin
            tick(s == 1);
            chk("R6 no early irq", irq, 0);
          end
          tick(s == 1);
          chk("R6 irq at N+1", irq, 1);
          rd(A_VAL, v); chk("R6 reload", v, n);
          tick(s == 1 ? 1'b0 : 1'b1);
          chk("R8 irq held", irq, 1);
          wr(A_CLR, 32'h1234_5678 * (p + 1));
          chk("R8 irq cleared", irq, 0);
        end
      end
    end
    // R7 free-running
    wr(A_CTRL, 0);
    wr(A_LOAD, 2);
    wr(A_CTRL, C_EN | C_FAST);
    tick(1); tick(1);
    chk("R7 no irq yet", irq, 0);
    tick(1);
    chk("R7 irq", irq, 1);
    rd(A_VAL, v); chk("R7 wrap", v, 32'hFFFF);
    tick(1);
    rd(A_VAL, v); chk("R7 continue", v, 32'hFFFE);
    // R10
    wr(A_CTRL, 0);
    chk("R10 irq kept", irq, 1);
    tick(1);
    rd(A_VAL, v); chk("R10 stopped", v, 32'hFFFE);
    // R9: clear and underflow together
    wr(A_LOAD, 0);
    wr(A_CTRL, C_EN | C_PER | C_FAST);
    @(negedge clk); req = 1; we = 1; addr = A_CLR; wdata = 0; tf = 1;
    @(negedge clk); req = 0; we = 0; tf = 0;
    chk("R9 underflow wins", irq, 1);
    wr(A_CLR, 0);
    chk("R9 later clear", irq, 0);
    // R12: load write with tick at zero
    @(negedge clk); req = 1; we = 1; addr = A_LOAD; wdata = 9; tf = 1;
    @(negedge clk); req = 0; we = 0; tf = 0;
    chk("R12 no underflow", irq, 0);
    rd(A_VAL, v); chk("R12 load wins", v, 9);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule